// File: doc/BRIEF.md
# Packed Signed 16-bit Multiply and Multiply-Accumulate Unit

This block takes two 64-bit operands, views each one as four signed 16-bit lanes, and forms the four lane-by-lane 32-bit products in one pass. A 2-bit opcode sets what goes into the 64-bit result. The unit can return the low half of every product, the high half of every product, or a pairwise sum: lanes 0 and 1 go into the lower 32-bit word and lanes 2 and 3 into the upper word. The pairwise sum is the building block of a dot product. The result is meant to overwrite the destination operand of the issuing instruction. Lane k always occupies bits [16k+15:16k].

The unit is a fixed two-stage pipeline. Stage one registers the four products. Stage two formats them and registers the result. The opcode and a caller-supplied tag travel with each operation, so every output can be matched to the operation that produced it.

Both ends use a valid/ready handshake. A transfer happens on a rising edge where valid and ready are both high. A producer keeps its payload steady until that edge. `in_ready` does not depend on `in_valid`. When the consumer holds `out_ready` low, the output stays frozen and the pipeline stalls. `in_ready` falls only when both stages hold data and the output is stalled. With `out_ready` held high, the unit takes one operation every cycle.

Top module: `pmul_unit`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_valid` is 0 and `in_ready` is 1.
- R2: Each operand is four signed 16-bit lanes, lane k in bits [16k+15:16k], and each lane product is the exact 32-bit signed product of the matching lanes. A lane whose operand is zero yields a zero product.
- R3: Opcode 2'b00 puts bits [15:0] of lane k's product into result lane k.
- R4: Opcode 2'b01 puts bits [31:16] of lane k's product into result lane k. For example, 0x8000 times 0x7FFF gives 0xC000.
- R5: Opcode 2'b10 places the sum of the lane 0 and lane 1 products in result[31:0] and the sum of the lane 2 and lane 3 products in result[63:32]. Each sum wraps modulo 2^32 with no saturation, so two products of -32768 times -32768 give 0x80000000.
- R6: Opcode 2'b11 yields an all-zero result.
- R7: An operation accepted on an edge appears with `out_valid` high two edges later, provided `out_ready` is high in between. With `out_ready` high, one operation is accepted per cycle.
- R8: `out_op` and `out_tag` equal the opcode and tag accepted with the same operation.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result`, `out_op` and `out_tag` hold steady into the next cycle. No operation is lost or duplicated.
- R10: Results leave in the order their operations were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can take an operation this cycle |
| in_op | input | 2 | 00 low half, 01 high half, 10 pairwise sum, 11 zero |
| in_a | input | 64 | Destination operand, four signed 16-bit lanes |
| in_b | input | 64 | Source operand, four signed 16-bit lanes |
| in_tag | input | TAG_W (4) | Caller tag carried with the operation |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_op | output | 2 | Opcode of the operation on the output |
| out_tag | output | TAG_W (4) | Tag of the operation on the output |
| out_result | output | 64 | Packed result |

## Verification
The embedded properties assume that `rst_n` is low at the first clock edge and that no other constraint applies to the inputs. Any opcode, any operand and any pattern on `out_ready` is legal, and the checks that compare output lanes against registered products hold only across an edge where the output register actually loaded. The stimulus holds each payload steady until it is accepted and changes inputs only in the settled part of the cycle. It keeps random `out_ready` toggling inside one phase, so the two-edge latency can be checked on every operation issued outside that phase.

// File: rtl/pmul_pkg.sv
package pmul_pkg;
  typedef enum logic [1:0] {
    OP_MUL_LO = 2'b00,
    OP_MUL_HI = 2'b01,
    OP_MADD   = 2'b10,
    OP_NONE   = 2'b11
  } pmul_op_e;
endpackage

// File: rtl/pmul_lane.sv
module pmul_lane #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           en,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic signed [PW-1:0] a_ext, b_ext, full;

  assign a_ext = {{W{a[W-1]}}, a};
  assign b_ext = {{W{b[W-1]}}, b};
  assign full  = a_ext * b_ext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  prod <= '0;
    else if (en) prod <= full;
  end

  // a zero operand must leave a zero product in the lane register
  assert_zero_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (a == '0 || b == '0) |=> prod == '0);
endmodule

// File: rtl/pmul_combine.sv
module pmul_combine
  import pmul_pkg::*;
#(
  parameter int LANES = 4,
  parameter int W     = 16
) (
  input  pmul_op_e               op,
  input  logic [LANES*2*W-1:0]   prod,
  output logic [LANES*W-1:0]     result
);
  localparam int PW    = 2 * W;
  localparam int PAIRS = LANES / 2;

  logic [LANES*W-1:0] lo_v, hi_v, madd_v;

  for (genvar k = 0; k < LANES; k++) begin : g_half
    assign lo_v[k*W +: W] = prod[k*PW +: W];
    assign hi_v[k*W +: W] = prod[k*PW + W +: W];
  end

  for (genvar j = 0; j < PAIRS; j++) begin : g_pair
    assign madd_v[j*PW +: PW] = prod[2*j*PW +: PW] + prod[(2*j+1)*PW +: PW];
  end

  always_comb begin
    unique case (op)
      OP_MUL_LO: result = lo_v;
      OP_MUL_HI: result = hi_v;
      OP_MADD:   result = madd_v;
      default:   result = '0;
    endcase
  end
endmodule

// File: rtl/pmul_unit.sv
module pmul_unit
  import pmul_pkg::*;
#(
  parameter int LANE_W = 16,
  parameter int LANES  = 4,
  parameter int TAG_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              in_op,
  input  logic [LANES*LANE_W-1:0] in_a,
  input  logic [LANES*LANE_W-1:0] in_b,
  input  logic [TAG_W-1:0]        in_tag,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [1:0]              out_op,
  output logic [TAG_W-1:0]        out_tag,
  output logic [LANES*LANE_W-1:0] out_result
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int PROD_W = 2 * LANE_W;

  logic                      adv1, adv2;
  logic                      s1_valid;
  pmul_op_e                  s1_op;
  logic [TAG_W-1:0]          s1_tag;
  logic [LANES*PROD_W-1:0]   s1_prod;
  logic [DATA_W-1:0]         fmt_result;

  assign adv2     = !out_valid || out_ready;
  assign adv1     = !s1_valid || adv2;
  assign in_ready = adv1;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pmul_lane #(.W(LANE_W)) u_lane (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (adv1),
      .a    (in_a[k*LANE_W +: LANE_W]),
      .b    (in_b[k*LANE_W +: LANE_W]),
      .prod (s1_prod[k*PROD_W +: PROD_W])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_op    <= OP_NONE;
      s1_tag   <= '0;
    end else if (adv1) begin
      s1_valid <= in_valid;
      s1_op    <= pmul_op_e'(in_op);
      s1_tag   <= in_tag;
    end
  end

  pmul_combine #(.LANES(LANES), .W(LANE_W)) u_combine (
    .op    (s1_op),
    .prod  (s1_prod),
    .result(fmt_result)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_op     <= 2'b11;
      out_tag    <= '0;
      out_result <= '0;
    end else if (adv2) begin
      out_valid  <= s1_valid;
      out_op     <= s1_op;
      out_tag    <= s1_tag;
      out_result <= fmt_result;
    end
  end

  assert_reset_R1: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

  assert_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) ##1 out_ready |=> out_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result)
                                 && $stable(out_op) && $stable(out_tag));

  assert_lane_lo_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv2) && out_valid && out_op == OP_MUL_LO
      |-> out_result[LANE_W-1:0] == $past(s1_prod[LANE_W-1:0]));

  assert_lane_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv2) && out_valid && out_op == OP_MUL_HI
      |-> out_result[LANE_W-1:0] == $past(s1_prod[PROD_W-1:LANE_W]));

  assert_madd_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv2) && out_valid && out_op == OP_MADD
      |-> out_result[PROD_W-1:0] ==
          $past(s1_prod[PROD_W-1:0] + s1_prod[2*PROD_W-1:PROD_W]));

  assert_zero_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_op == OP_NONE |-> out_result == '0);
endmodule

// File: tb/pmul_unit_tb.sv
module pmul_unit_tb;
  localparam int TAG_W = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n, in_valid, in_ready, out_valid;
  logic              out_ready = 1'b1;
  logic [1:0]        in_op, out_op;
  logic [63:0]       in_a, in_b, out_result;
  logic [TAG_W-1:0]  in_tag, out_tag;

  pmul_unit #(.LANE_W(16), .LANES(4), .TAG_W(TAG_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_tag(in_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_op(out_op),
    .out_tag(out_tag), .out_result(out_result)
  );

  typedef struct packed {
    logic [1:0]  op;
    logic [63:0] a;
    logic [63:0] b;
    logic [63:0] r;
  } vec_t;

  // hand-computed vectors; lanes written 3..0 from left
  localparam vec_t VECS [7] = '{
    '{2'b00, 64'h0002_0003_FFFF_7FFF, 64'h0004_0005_FFFF_0002, 64'h0008_000F_0001_FFFE},
    '{2'b01, 64'h8000_8000_7FFF_FFFF, 64'h8000_7FFF_7FFF_0002, 64'h4000_C000_3FFF_FFFF},
    '{2'b10, 64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 64'h8000_0000_8000_0000},
    '{2'b10, 64'h0001_0002_0003_0004, 64'h0005_0006_0007_0008, 64'h0000_0011_0000_0035},
    '{2'b10, 64'hFFFF_0000_7FFF_8000, 64'h0001_1234_7FFF_7FFF, 64'hFFFF_FFFF_FFFF_8001},
    '{2'b11, 64'h1234_8000_FFFF_7FFF, 64'h7FFF_8000_FFFF_0001, 64'h0000_0000_0000_0000},
    '{2'b00, 64'h8000_8000_0000_7FFF, 64'h8000_FFFF_1234_7FFF, 64'h0000_8000_0000_0001}
  };

  int n_cmp = 0, n_bad = 0, cyc = 0, last_stall = -1;
  logic bp_mode = 1'b0;
  logic [TAG_W-1:0] tag_ctr = '0;
  logic [63:0] exp_next;
  logic [63:0] q_res [$];
  logic [1:0]  q_op  [$];
  logic [TAG_W-1:0] q_tag [$];
  int q_cyc [$];
  logic prev_hold = 1'b0;
  logic [63:0] prev_res;
  logic [1:0] prev_op;
  logic [TAG_W-1:0] prev_tag;

  function automatic string req_of(logic [1:0] op);
    case (op)
      2'b00: return "R3";
      2'b01: return "R4";
      2'b10: return "R5";
      default: return "R6";
    endcase
  endfunction

  function automatic logic [63:0] model(logic [1:0] op, logic [63:0] a, logic [63:0] b);
    logic [31:0] p [4];
    logic [63:0] r;
    for (int k = 0; k < 4; k++) begin
      int x, y;
      x = int'($signed(a[16*k +: 16]));
      y = int'($signed(b[16*k +: 16]));
      p[k] = 32'(x * y);
    end
    case (op)
      2'b00: r = {p[3][15:0], p[2][15:0], p[1][15:0], p[0][15:0]};
      2'b01: r = {p[3][31:16], p[2][31:16], p[1][31:16], p[0][31:16]};
      2'b10: r = {32'(p[3] + p[2]), 32'(p[1] + p[0])};
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pick();
    case ($urandom_range(0, 5))
      0: return 16'h8000;
      1: return 16'hFFFF;
      2: return 16'h0000;
      3: return 16'h7FFF;
      default: return 16'($urandom);
    endcase
  endfunction

  // monitor and scoreboard, sampling in the settled half of the cycle
  always @(negedge clk) begin
    cyc++;
    if (rst_n === 1'b1) begin
      if (prev_hold)
        check(out_valid && out_result == prev_res && out_op == prev_op && out_tag == prev_tag,
              "R9", "stalled output changed", out_result, prev_res);
      prev_hold = out_valid && !out_ready;
      prev_res  = out_result;
      prev_op   = out_op;
      prev_tag  = out_tag;
      if (!out_ready) last_stall = cyc;
      if (out_valid && out_ready) begin
        if (q_res.size() == 0) begin
          check(1'b0, "R10", "output with nothing outstanding", out_result, 64'h0);
        end else begin
          logic [63:0] er;
          logic [1:0] eo;
          logic [TAG_W-1:0] et;
          int ec;
          er = q_res.pop_front(); eo = q_op.pop_front();
          et = q_tag.pop_front(); ec = q_cyc.pop_front();
          check(out_result == er, req_of(eo), "result (R2 lane layout)", out_result, er);
          check(out_op == eo && out_tag == et, "R8/R10", "op and tag",
                {58'h0, out_op, out_tag}, {58'h0, eo, et});
          if (ec > last_stall)
            check(cyc - ec == 2, "R7", "latency", 64'(cyc - ec), 64'd2);
        end
      end
      if (in_valid && in_ready) begin
        q_res.push_back(exp_next); q_op.push_back(in_op);
        q_tag.push_back(in_tag);   q_cyc.push_back(cyc);
      end
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = bp_mode ? ($urandom_range(0, 2) != 0) : 1'b1;
  end

  task automatic send(logic [1:0] op, logic [63:0] a, logic [63:0] b, logic [63:0] r);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    in_tag = tag_ctr; exp_next = r; tag_ctr++;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic send_rand(int n);
    for (int i = 0; i < n; i++) begin
      logic [1:0] op;
      logic [63:0] a, b;
      op = 2'($urandom_range(0, 3));
      a = {pick(), pick(), pick(), pick()};
      b = {pick(), pick(), pick(), pick()};
      send(op, a, b, model(op, a, b));
    end
  endtask

  task automatic run_tests();
    rst_n = 1'b0; in_valid = 1'b0; in_op = '0; in_a = '0; in_b = '0; in_tag = '0;
    exp_next = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid in reset", {63'h0, out_valid}, 64'h0);
    check(in_ready == 1'b1, "R1", "in_ready in reset", {63'h0, in_ready}, 64'h1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R1", "first cycle after reset",
          {62'h0, out_valid, in_ready}, 64'h1);
    @(posedge clk); #1;
    // table of vectors, issued back to back
    for (int i = 0; i < 7; i++) send(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].r);
    // pairwise-sum wrap corner and zero-lane corner (R5, R2)
    send(2'b10, {4{16'h8000}}, {4{16'h8000}}, 64'h8000_0000_8000_0000);
    send(2'b01, 64'h0000_7FFF_8000_0000, 64'h8000_0000_7FFF_FFFF, 64'h0000_0000_C000_0000);
    send_rand(300);                 // full throughput, R7
    bp_mode = 1'b1;
    send_rand(300);                 // random back-pressure, R9
    bp_mode = 1'b0;
    send_rand(50);
    repeat (8) @(negedge clk);
    check(q_res.size() == 0, "R9", "operations left undelivered",
          64'(q_res.size()), 64'h0);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_tests();
      begin
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) check(1'b0, "R7", "watchdog expired", 64'h0, 64'h1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule